// File: doc/BRIEF.md
# Interrupt Nesting Status Controller

This block keeps a two-bit nesting code for a small 4-bit controller core. From that code it decides whether a pending interrupt request may be taken. A request arrives as a valid bit plus a priority bit. The block answers combinationally with a permission signal, which plays the part of a ready: the requester holds `req_valid` and `req_high` steady until the core issues `ack`. A request that is not permitted waits, and the block never drops it. The nesting code moves up by one on each acknowledge. On return-from-interrupt it is reloaded from the value popped off the stack. Software may also overwrite the code through a write port.

Next to the nesting code the block holds a memory-bank-enable bit. Reset loads this bit from bit 7 of the boot word. An acknowledge loads it from bit 7 of the vector-table word, and a return restores it from the stack. In the acknowledge cycle the block presents the code and bank bit it held before the acknowledge, so that the stack logic can push them.

Top module: `intr_nest_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `status` is 00, `proto_err` is 0 and `mbe` equals `boot_word` bit 7.
- R2: With `status` = 00, `accept` equals `req_valid` whatever `req_high` is. With `req_valid` = 0, `accept` is 0 in every state.
- R3: With `status` = 01, `accept` is 1 only when `req_valid` = 1 and `req_high` = 1.
- R4: With `status` = 10, `accept` is 0 for every request.
- R5: In an `ack` cycle without `reti`, `push_status` shows the current code and the code rises by one on the next edge. An `ack` while the code is 10 leaves it at 10.
- R6: In an `ack` cycle without `reti`, `push_mbe` shows the current bank bit, and `mbe` takes `vec_word` bit 7 on the next edge.
- R7: In a `reti` cycle, `status` takes `pop_status` and `mbe` takes `pop_mbe` on the next edge. A popped code of 11 leaves `status` unchanged, but `mbe` is still restored.
- R8: When neither `ack` nor `reti` is high, `sw_we` = 1 writes `sw_status` into `status` on the next edge.
- R9: A software write of 11 is ignored and `status` keeps its value. `status` never reads 11.
- R10: `ack` and `reti` high in the same cycle is a protocol error. `reti` takes effect, `ack` is ignored, and `proto_err` is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_word | input | WORD_W | Word at program address 0; its bank bit seeds `mbe` |
| req_valid | input | 1 | An interrupt request is pending |
| req_high | input | 1 | The pending request has high priority |
| accept | output | 1 | The pending request may be acknowledged now |
| ack | input | 1 | Acknowledge strobe |
| vec_word | input | WORD_W | Vector-table word of the acknowledged source |
| reti | input | 1 | Return-from-interrupt strobe |
| pop_status | input | 2 | Nesting code popped from the stack |
| pop_mbe | input | 1 | Bank bit popped from the stack |
| sw_we | input | 1 | Software write enable for the nesting code |
| sw_status | input | 2 | Software write data |
| status | output | 2 | Current nesting code |
| mbe | output | 1 | Current memory-bank-enable bit |
| push_status | output | 2 | Nesting code to push on acknowledge |
| push_mbe | output | 1 | Bank bit to push on acknowledge |
| proto_err | output | 1 | One-cycle flag after `ack` and `reti` collided |

## Verification
Three writers can fall on the nesting code in the same cycle: a return, an acknowledge and a software write. The case that matters most is `ack` and `reti` together. The bench drives this collision from each nesting level, with pop values that differ from what an acknowledge would give. It then judges the cycle by three results: the popped code and bank bit win, the vector word's bit is discarded, and `proto_err` is high for a single cycle. The bench also pairs software writes with strobes in the same cycle, to confirm that the write loses.

// File: rtl/nest_pkg.sv
package nest_pkg;
  localparam int ST_W = 2;
  typedef logic [ST_W-1:0] nest_t;
  localparam nest_t ST_NONE = 2'b00;
  localparam nest_t ST_ANY  = 2'b01;
  localparam nest_t ST_HIGH = 2'b10;
  localparam nest_t ST_BAD  = 2'b11;

  function automatic logic nest_legal(input nest_t v);
    return v != ST_BAD;
  endfunction
endpackage

// File: rtl/nest_gate.sv
module nest_gate
  import nest_pkg::*;
(
  input  nest_t st,
  input  logic  req_valid,
  input  logic  req_high,
  output logic  accept
);
  always_comb begin
    unique case (st)
      ST_NONE: accept = req_valid;
      ST_ANY:  accept = req_valid & req_high;
      default: accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/nest_status_reg.sv
module nest_status_reg
  import nest_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ack,
  input  logic  reti,
  input  nest_t pop_st,
  input  logic  sw_we,
  input  nest_t sw_st,
  output nest_t st,
  output logic  err
);
  nest_t st_q, st_d;
  logic  err_q;

  always_comb begin
    st_d = st_q;
    if (reti) begin
      if (nest_legal(pop_st)) st_d = pop_st;
    end else if (ack) begin
      if (st_q != ST_HIGH) st_d = st_q + 2'd1;
    end else if (sw_we && nest_legal(sw_st)) begin
      st_d = sw_st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_NONE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= ack & reti;
    end
  end

  assign st  = st_q;
  assign err = err_q;
endmodule

// File: rtl/nest_bank_reg.sv
module nest_bank_reg #(
  parameter int WORD_W   = 8,
  parameter int BANK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] boot_word,
  input  logic              ack,
  input  logic [WORD_W-1:0] vec_word,
  input  logic              reti,
  input  logic              pop_bit,
  output logic              bank
);
  logic bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    bank_q <= boot_word[BANK_BIT];
    else if (reti) bank_q <= pop_bit;
    else if (ack)  bank_q <= vec_word[BANK_BIT];
  end

  assign bank = bank_q;
endmodule

// File: rtl/intr_nest_ctrl.sv
module intr_nest_ctrl
  import nest_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int BANK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] boot_word,
  input  logic              req_valid,
  input  logic              req_high,
  output logic              accept,
  input  logic              ack,
  input  logic [WORD_W-1:0] vec_word,
  input  logic              reti,
  input  logic [1:0]        pop_status,
  input  logic              pop_mbe,
  input  logic              sw_we,
  input  logic [1:0]        sw_status,
  output logic [1:0]        status,
  output logic              mbe,
  output logic [1:0]        push_status,
  output logic              push_mbe,
  output logic              proto_err
);
  localparam int BIT_OK = (BANK_BIT < WORD_W) ? 1 : 0;

  nest_t st_w;
  logic  bank_w;

  generate
    if (BIT_OK == 0) begin : g_bad_param
      initial $error("BANK_BIT outside WORD_W");
    end
  endgenerate

  nest_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .pop_st(pop_status),
    .sw_we(sw_we), .sw_st(sw_status), .st(st_w), .err(proto_err)
  );

  nest_bank_reg #(.WORD_W(WORD_W), .BANK_BIT(BANK_BIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .boot_word(boot_word), .ack(ack),
    .vec_word(vec_word), .reti(reti), .pop_bit(pop_mbe), .bank(bank_w)
  );

  nest_gate u_gate (
    .st(st_w), .req_valid(req_valid), .req_high(req_high), .accept(accept)
  );

  assign status      = st_w;
  assign mbe         = bank_w;
  assign push_status = st_w;
  assign push_mbe    = bank_w;
endmodule

// File: rtl/intr_nest_ctrl_chk.sv
module intr_nest_ctrl_chk #(
  parameter int WORD_W   = 8,
  parameter int BANK_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_high,
  input logic              accept,
  input logic              ack,
  input logic [WORD_W-1:0] vec_word,
  input logic              reti,
  input logic [1:0]        pop_status,
  input logic              pop_mbe,
  input logic              sw_we,
  input logic [1:0]        sw_status,
  input logic [1:0]        status,
  input logic              mbe,
  input logic              proto_err
);
  assert_never_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b10) |-> !accept);
  assert_low_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && accept) |-> req_high);
  assert_ack_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !reti && status != 2'b10) |=> status == $past(status) + 2'd1);
  assert_ack_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !reti) |=> mbe == $past(vec_word[BANK_BIT]));
  assert_ret_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && pop_status != 2'b11) |=> (status == $past(pop_status) && mbe == $past(pop_mbe)));
  assert_sw_bad_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_status == 2'b11 && !ack && !reti) |=> $stable(status));
  assert_collision_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && reti) |=> proto_err);
  assert_flag_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && reti) |=> !proto_err);
endmodule

bind intr_nest_ctrl intr_nest_ctrl_chk #(.WORD_W(WORD_W), .BANK_BIT(BANK_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_high(req_high),
  .accept(accept), .ack(ack), .vec_word(vec_word), .reti(reti),
  .pop_status(pop_status), .pop_mbe(pop_mbe), .sw_we(sw_we),
  .sw_status(sw_status), .status(status), .mbe(mbe), .proto_err(proto_err)
);

// File: tb/test_intr_nest_ctrl.sv
`timescale 1ns/1ps
module test_intr_nest_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] boot_word = 8'h80, vec_word = 0;
  logic req_valid = 0, req_high = 0, ack = 0, reti = 0, pop_mbe = 0, sw_we = 0;
  logic [1:0] pop_status = 0, sw_status = 0;
  logic accept, mbe, push_mbe, proto_err;
  logic [1:0] status, push_status;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [1:0] st; logic bank; logic err; string tag; } exp_t;
  exp_t q[$];
  logic [1:0] m_st;
  logic m_bank;

  always #2 clk = ~clk;

  intr_nest_ctrl i_intr_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_word(boot_word), .req_valid(req_valid),
    .req_high(req_high), .accept(accept), .ack(ack), .vec_word(vec_word),
    .reti(reti), .pop_status(pop_status), .pop_mbe(pop_mbe), .sw_we(sw_we),
    .sw_status(sw_status), .status(status), .mbe(mbe),
    .push_status(push_status), .push_mbe(push_mbe), .proto_err(proto_err)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, checks combinational outputs, queues the post-edge state
  task automatic cyc(string tag, logic a, logic [7:0] vw, logic r, logic [1:0] ps,
                     logic pm, logic we, logic [1:0] sd, logic rv, logic rh);
    logic exp_acc;
    exp_t e;
    @(negedge clk);
    ack = a; vec_word = vw; reti = r; pop_status = ps; pop_mbe = pm;
    sw_we = we; sw_status = sd; req_valid = rv; req_high = rh;
    #1;
    exp_acc = rv && (m_st == 2'b00 || (m_st == 2'b01 && rh));
    chk({tag, " accept"}, {3'b0, accept}, {3'b0, exp_acc});
    if (a) begin
      chk({tag, " push_status"}, {2'b0, push_status}, {2'b0, m_st});
      chk({tag, " push_mbe"}, {3'b0, push_mbe}, {3'b0, m_bank});
    end
    if (r) begin
      if (ps != 2'b11) m_st = ps;
      m_bank = pm;
    end else if (a) begin
      if (m_st != 2'b10) m_st = m_st + 2'd1;
      m_bank = vw[7];
    end else if (we && sd != 2'b11) m_st = sd;
    e.st = m_st; e.bank = m_bank; e.err = a & r; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares the registered state after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " status"}, {2'b0, status}, {2'b0, e.st});
      chk({e.tag, " mbe"}, {3'b0, mbe}, {3'b0, e.bank});
      chk({e.tag, " proto_err"}, {3'b0, proto_err}, {3'b0, e.err});
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset mbe", {3'b0, mbe}, 4'd1);
    rst_n = 1; boot_word = 8'h00;
    #1;
    chk("R1 status", {2'b0, status}, 4'd0);
    chk("R1 mbe", {3'b0, mbe}, 4'd1);
    chk("R1 proto_err", {3'b0, proto_err}, 4'd0);
    m_st = 2'b00; m_bank = 1'b1;
    // R2 idle acceptance
    cyc("R2 idle low", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R2 idle high", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R2 no req", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R5 R6 ack climbs, bank from vector bit 7
    cyc("R5 ack from 00", 1, 8'h7F, 0, 0, 0, 0, 0, 1, 0);
    cyc("R3 low at 01", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R3 high at 01", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R6 ack from 01", 1, 8'h80, 0, 0, 0, 0, 0, 1, 1);
    cyc("R4 high at 10", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R4 low at 10", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R5 ack saturates", 1, 8'h00, 0, 0, 0, 0, 0, 1, 1);
    // R9 ignored writes, R8 lower priority
    cyc("R9 sw 11", 0, 0, 0, 0, 0, 1, 2'b11, 0, 0);
    cyc("R8 sw 01", 0, 0, 0, 0, 0, 1, 2'b01, 0, 0);
    cyc("R8 sw loses to ack", 1, 8'h80, 0, 0, 0, 1, 2'b00, 0, 0);
    cyc("R8 sw 00", 0, 0, 0, 0, 0, 1, 2'b00, 1, 0);
    cyc("R9 sw 11 at 00", 0, 0, 0, 0, 0, 1, 2'b11, 1, 0);
    // R7 returns
    cyc("R5 ack to 01", 1, 8'h00, 0, 0, 0, 0, 0, 1, 0);
    cyc("R7 reti pop 00", 0, 0, 1, 2'b00, 1, 0, 0, 1, 0);
    cyc("R7 reti pop 10", 0, 0, 1, 2'b10, 0, 0, 0, 1, 1);
    cyc("R7 reti pop 11", 0, 0, 1, 2'b11, 1, 0, 0, 0, 0);
    cyc("R8 sw loses to reti", 0, 0, 1, 2'b01, 0, 1, 2'b00, 0, 0);
    // R10 collisions from every level
    for (int l = 0; l < 3; l++) begin
      cyc("R8 set level", 0, 0, 0, 0, 0, 1, 2'(l), 0, 0);
      cyc("R10 collide", 1, 8'h80, 1, 2'(2 - l), 0, 0, 0, 1, 1);
      cyc("R10 flag clears", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    end
    cyc("R10 collide pop 11", 1, 8'h00, 1, 2'b11, 1, 0, 0, 0, 0);
    cyc("R10 back-to-back", 1, 8'h00, 1, 2'b00, 0, 0, 0, 0, 0);
    cyc("R10 flag clears", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule